// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer with Early-Warning Interrupt

This block is a watchdog peripheral on a plain 32-bit register bus. Software stages a 32-bit reload value and a 32-bit early-warning threshold. Each value is split into two 16-bit halves. A reload copies both staged values into the live counter after a short settling window. While enabled, the counter counts down once per pulse of a slow tick-enable input. The rate of that input is 32768 pulses per second, and the supported timeout span is 3 to 60 seconds.

When the count steps onto the threshold, an interrupt event is latched. The interrupt event can be enabled and masked. When the count steps onto zero with reset generation enabled, a reset event is latched and a one-cycle reset pulse is driven. The counter then sits at zero until the next reload.

Every write except the one to the key register is ignored until the unlock key has been written. Reads are never blocked. The whole block runs on a single clock.

Top module: `wdk_top`

## Requirements
- R1: After reset the block is locked. Control, mask, staged values, count and status all read 0, and both `irq_o` and `wdt_rst_o` are low.
- R2: A write to offset 0x20 whose low 16 bits equal KEY (default 0xE551) unlocks the block, and a write of any other value locks it. Reading 0x20 returns the lock state in bit 0 (1 = unlocked). While the block is locked, writes to every other offset have no effect.
- R3: The control register is at offset 0x08. Bit 0 is interrupt enable, bit 1 is count enable, bit 2 is a stored mode bit with no other effect, and bit 3 is reset enable. All four bits read back as written.
- R4: A write to reload-low (0x00) sets raw status (0x10) bit 4. That bit stays set for BUSY_TICKS tick pulses. On the last of those pulses the count takes {reload-high 0x04, reload-low}, the threshold takes {threshold-high 0x30, threshold-low 0x2C}, and bit 4 clears. No decrement happens while bit 4 is set.
- R5: With control bit 1 set, the count decreases by exactly one per tick pulse, with borrow across the 16-bit halves. With bit 1 clear it holds. It never wraps below zero.
- R6: Reading count-high (0x1C) returns count bits 31:16 and captures bits 15:0 into a snapshot. Count-low (0x18) returns that snapshot.
- R7: When a decrement lands on the threshold, raw status bit 0 is set. `irq_o` is high exactly while raw bit 0, control bit 0 are set and mask (0x14) bit 0 is clear.
- R8: Writing 1 to bit 0 of the clear register (0x0C) clears raw bit 0, and writing 1 to bit 3 clears raw bit 3.
- R9: A decrement onto zero with control bit 3 set sets raw bit 3 and drives `wdt_rst_o` high for exactly the next cycle. With bit 3 clear, neither happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow countdown tick enable, one cycle per step |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the count snapshot) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset currently on bus_addr |
| irq_o | output | 1 | Early-warning interrupt |
| wdt_rst_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its defaults: BUSY_TICKS of 2 and the 0xE551 key. This makes the settling window two tick pulses long, so the window can be walked pulse by pulse. The reload values are tiny, such as 5 with a threshold of 2, or 0x00010002, so the threshold crossing, the zero-reach pulse and the borrow across the 16-bit halves all occur within a few ticks. These small values still exercise the full 32-bit datapath.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int HALF_W = 16;
  localparam int CNT_W  = 2 * HALF_W;
  localparam int AW     = 8;

  localparam logic [AW-1:0] OFS_LD_LO = 8'h00;
  localparam logic [AW-1:0] OFS_LD_HI = 8'h04;
  localparam logic [AW-1:0] OFS_CTRL  = 8'h08;
  localparam logic [AW-1:0] OFS_CLR   = 8'h0C;
  localparam logic [AW-1:0] OFS_RAW   = 8'h10;
  localparam logic [AW-1:0] OFS_MASK  = 8'h14;
  localparam logic [AW-1:0] OFS_CNT_LO = 8'h18;
  localparam logic [AW-1:0] OFS_CNT_HI = 8'h1C;
  localparam logic [AW-1:0] OFS_LOCK  = 8'h20;
  localparam logic [AW-1:0] OFS_PR_LO = 8'h2C;
  localparam logic [AW-1:0] OFS_PR_HI = 8'h30;

  localparam int C_IRQ_EN = 0;
  localparam int C_CNT_EN = 1;
  localparam int C_RST_EN = 3;
  localparam int CTRL_W   = 4;

  localparam int S_INT  = 0;
  localparam int S_RST  = 3;
  localparam int S_BUSY = 4;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter logic [HALF_W-1:0] KEY = 16'hE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  output logic              unlocked,
  output logic [CTRL_W-1:0] ctrl,
  output logic              irq_mask,
  output logic [HALF_W-1:0] ld_lo,
  output logic [HALF_W-1:0] ld_hi,
  output logic [HALF_W-1:0] pr_lo,
  output logic [HALF_W-1:0] pr_hi,
  output logic              load_start,
  output logic              clr_int,
  output logic              clr_rst
);
  logic              wr_ok;
  logic              unl_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              mask_d;
  logic [HALF_W-1:0] ld_lo_d, ld_hi_d, pr_lo_d, pr_hi_d;

  always_comb begin
    wr_ok      = wr && unlocked;
    unl_d      = unlocked;
    ctrl_d     = ctrl;
    mask_d     = irq_mask;
    ld_lo_d    = ld_lo;
    ld_hi_d    = ld_hi;
    pr_lo_d    = pr_lo;
    pr_hi_d    = pr_hi;
    load_start = 1'b0;
    clr_int    = 1'b0;
    clr_rst    = 1'b0;
    if (wr && addr == OFS_LOCK) unl_d = (wdata[HALF_W-1:0] == KEY);
    if (wr_ok) begin
      case (addr)
        OFS_LD_LO: begin
          ld_lo_d    = wdata[HALF_W-1:0];
          load_start = 1'b1;
        end
        OFS_LD_HI: ld_hi_d = wdata[HALF_W-1:0];
        OFS_PR_LO: pr_lo_d = wdata[HALF_W-1:0];
        OFS_PR_HI: pr_hi_d = wdata[HALF_W-1:0];
        OFS_CTRL:  ctrl_d  = wdata[CTRL_W-1:0];
        OFS_MASK:  mask_d  = wdata[0];
        OFS_CLR: begin
          clr_int = wdata[S_INT];
          clr_rst = wdata[S_RST];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      ctrl     <= '0;
      irq_mask <= 1'b0;
      ld_lo    <= '0;
      ld_hi    <= '0;
      pr_lo    <= '0;
      pr_hi    <= '0;
    end else begin
      unlocked <= unl_d;
      ctrl     <= ctrl_d;
      irq_mask <= mask_d;
      ld_lo    <= ld_lo_d;
      ld_hi    <= ld_hi_d;
      pr_lo    <= pr_lo_d;
      pr_hi    <= pr_hi_d;
    end
  end

  // R2: a locked block keeps its control setting
  a_r2_locked_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(ctrl));
  // R2: a locked block raises no reload
  a_r2_locked_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !load_start);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W      = 32,
  parameter int BUSY_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_en,
  input  logic             rst_en,
  input  logic             load_start,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] pre_val,
  input  logic             clr_int,
  input  logic             clr_rst,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             int_evt,
  output logic             rst_evt,
  output logic             rst_pulse
);
  localparam int BW = (BUSY_TICKS > 1) ? $clog2(BUSY_TICKS) : 1;
  localparam logic [BW-1:0] B_LAST = BW'(BUSY_TICKS - 1);

  logic [BW-1:0]    bcnt, bcnt_d;
  logic [CNT_W-1:0] pre_thr, pre_d, count_d, nxt;
  logic             busy_d, int_d, rst_d, pulse_d, dec, load_done;

  always_comb begin
    nxt       = count - 1'b1;
    load_done = busy && tick && (bcnt == B_LAST) && !load_start;
    dec       = cnt_en && tick && !busy && (count != '0) && !load_start;
    busy_d    = busy;
    bcnt_d    = bcnt;
    count_d   = count;
    pre_d     = pre_thr;
    if (load_start) begin
      busy_d = 1'b1;
      bcnt_d = '0;
    end else if (load_done) begin
      busy_d  = 1'b0;
      count_d = load_val;
      pre_d   = pre_val;
    end else if (busy && tick) begin
      bcnt_d = bcnt + 1'b1;
    end else if (dec) begin
      count_d = nxt;
    end
    pulse_d = dec && rst_en && (nxt == '0);
    int_d   = clr_int ? 1'b0 : int_evt;
    if (dec && nxt == pre_thr) int_d = 1'b1;
    rst_d   = clr_rst ? 1'b0 : rst_evt;
    if (pulse_d) rst_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bcnt      <= '0;
      count     <= '0;
      pre_thr   <= '0;
      int_evt   <= 1'b0;
      rst_evt   <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      busy      <= busy_d;
      bcnt      <= bcnt_d;
      count     <= count_d;
      pre_thr   <= pre_d;
      int_evt   <= int_d;
      rst_evt   <= rst_d;
      rst_pulse <= pulse_d;
    end
  end

  // R9: reset request lasts one cycle
  a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  // R9: the pulse comes with a latched reset event
  a_r9_pulse_has_event: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> rst_evt);
  // R4: no counting inside the settling window
  a_r4_busy_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_d) |=> $stable(count));
  // R5: count never wraps below zero
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !busy) |=> (count == '0));
  // R5: an enabled tick takes exactly one step
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && tick && !busy && !load_start && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/wdk_rdmux.sv
module wdk_rdmux
  import wdk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic              unlocked,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              irq_mask,
  input  logic [HALF_W-1:0] ld_lo,
  input  logic [HALF_W-1:0] ld_hi,
  input  logic [HALF_W-1:0] pr_lo,
  input  logic [HALF_W-1:0] pr_hi,
  input  logic [CNT_W-1:0]  count,
  input  logic              busy,
  input  logic              int_evt,
  input  logic              rst_evt,
  output logic [31:0]       rdata
);
  logic [HALF_W-1:0] snap_q, snap_d;
  logic [31:0]       raw;

  always_comb begin
    snap_d = (rd && addr == OFS_CNT_HI) ? count[HALF_W-1:0] : snap_q;
    raw         = '0;
    raw[S_INT]  = int_evt;
    raw[S_RST]  = rst_evt;
    raw[S_BUSY] = busy;
    case (addr)
      OFS_LD_LO:  rdata = 32'(ld_lo);
      OFS_LD_HI:  rdata = 32'(ld_hi);
      OFS_PR_LO:  rdata = 32'(pr_lo);
      OFS_PR_HI:  rdata = 32'(pr_hi);
      OFS_CTRL:   rdata = 32'(ctrl);
      OFS_MASK:   rdata = 32'(irq_mask);
      OFS_RAW:    rdata = raw;
      OFS_CNT_HI: rdata = 32'(count[CNT_W-1:HALF_W]);
      OFS_CNT_LO: rdata = 32'(snap_q);
      OFS_LOCK:   rdata = 32'(unlocked);
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  // R6: snapshot only moves on a read of the high half
  a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && addr == OFS_CNT_HI) |=> $stable(snap_q));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter logic [HALF_W-1:0] KEY        = 16'hE551,
  parameter int                BUSY_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o,
  output logic          wdt_rst_o
);
  logic              unlocked, irq_mask, load_start, clr_int, clr_rst;
  logic [CTRL_W-1:0] ctrl;
  logic [HALF_W-1:0] ld_lo, ld_hi, pr_lo, pr_hi;
  logic [CNT_W-1:0]  count;
  logic              busy, int_evt, rst_evt;

  wdk_regs #(.KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .unlocked(unlocked), .ctrl(ctrl), .irq_mask(irq_mask),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .pr_lo(pr_lo), .pr_hi(pr_hi),
    .load_start(load_start), .clr_int(clr_int), .clr_rst(clr_rst)
  );

  wdk_counter #(.CNT_W(CNT_W), .BUSY_TICKS(BUSY_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_en(ctrl[C_CNT_EN]), .rst_en(ctrl[C_RST_EN]),
    .load_start(load_start), .load_val({ld_hi, ld_lo}), .pre_val({pr_hi, pr_lo}),
    .clr_int(clr_int), .clr_rst(clr_rst),
    .count(count), .busy(busy), .int_evt(int_evt), .rst_evt(rst_evt),
    .rst_pulse(wdt_rst_o)
  );

  wdk_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .unlocked(unlocked), .ctrl(ctrl), .irq_mask(irq_mask),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .pr_lo(pr_lo), .pr_hi(pr_hi),
    .count(count), .busy(busy), .int_evt(int_evt), .rst_evt(rst_evt),
    .rdata(bus_rdata)
  );

  assign irq_o = int_evt && ctrl[C_IRQ_EN] && !irq_mask;

  // R7: a masked interrupt stays quiet
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq_o);
endmodule

// File: tb/wdk_top_bench.sv
module wdk_top_bench;
  logic        clk, rst_n, tick, bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, wdt_rst_o;
  int          total, bad;

  wdk_top u_wdk_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd_count(output logic [31:0] c);
    logic [31:0] h, l;
    rd(8'h1C, h);
    rd(8'h18, l);
    c = {h[15:0], l[15:0]};
  endtask

  task automatic load(input logic [31:0] v, input logic [31:0] p);
    wr(8'h04, v >> 16);
    wr(8'h30, p >> 16);
    wr(8'h2C, p & 32'hFFFF);
    wr(8'h00, v & 32'hFFFF);
    pulse_tick();
    pulse_tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h20, d); check("R1 lock", d, 0);
    rd(8'h08, d); check("R1 ctrl", d, 0);
    rd(8'h10, d); check("R1 raw", d, 0);
    rd_count(d);  check("R1 count", d, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 rst", {31'b0, wdt_rst_o}, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(8'h08, 32'hF);
    rd(8'h08, d); check("R2 locked ctrl write ignored", d, 0);
    wr(8'h00, 32'h5);
    rd(8'h10, d); check("R2 locked reload ignored", d, 0);
    wr(8'h20, 32'hE551);
    rd(8'h20, d); check("R2 unlocked", d, 1);
    wr(8'h08, 32'hF);
    rd(8'h08, d); check("R3 ctrl readback", d, 32'hF);
    wr(8'h20, 32'h1234);
    rd(8'h20, d); check("R2 relocked", d, 0);
    wr(8'h08, 32'h0);
    rd(8'h08, d); check("R2 relocked ctrl kept", d, 32'hF);
    wr(8'h20, 32'hE551);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_busy_and_split();
    logic [31:0] d;
    wr(8'h04, 32'h1);
    wr(8'h2C, 32'h0);
    wr(8'h30, 32'h0);
    wr(8'h08, 32'h2);
    wr(8'h00, 32'h2);
    rd(8'h10, d); check("R4 busy set", d, 32'h10);
    pulse_tick();
    rd(8'h10, d); check("R4 busy after one tick", d, 32'h10);
    rd_count(d);  check("R4 count frozen while busy", d, 0);
    pulse_tick();
    rd(8'h10, d); check("R4 busy cleared", d, 0);
    rd_count(d);  check("R6 count pair after load", d, 32'h0001_0002);
    repeat (3) pulse_tick();
    rd_count(d);  check("R5 borrow across halves", d, 32'h0000_FFFF);
    wr(8'h08, 32'h0);
    repeat (2) pulse_tick();
    rd_count(d);  check("R5 disabled holds", d, 32'h0000_FFFF);
  endtask

  task automatic t_countdown();
    logic [31:0] d;
    wr(8'h08, 32'h0);
    load(32'd5, 32'd2);
    wr(8'h14, 32'h0);
    wr(8'h08, 32'hB);
    pulse_tick(); pulse_tick();
    check("R7 no irq above threshold", {31'b0, irq_o}, 0);
    pulse_tick();
    check("R7 irq at threshold", {31'b0, irq_o}, 1);
    wr(8'h14, 32'h1);
    check("R7 masked irq", {31'b0, irq_o}, 0);
    rd(8'h10, d); check("R7 raw kept while masked", d, 32'h1);
    wr(8'h14, 32'h0);
    check("R7 unmasked irq", {31'b0, irq_o}, 1);
    wr(8'h0C, 32'h1);
    rd(8'h10, d); check("R8 int event cleared", d, 0);
    check("R8 irq after clear", {31'b0, irq_o}, 0);
    pulse_tick();
    check("R9 no pulse at one", {31'b0, wdt_rst_o}, 0);
    pulse_tick();
    check("R9 pulse at zero", {31'b0, wdt_rst_o}, 1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'b0, wdt_rst_o}, 0);
    rd(8'h10, d); check("R9 rst event", d, 32'h8);
    pulse_tick(); pulse_tick();
    rd_count(d); check("R5 stays at zero", d, 0);
    check("R9 no repeat pulse", {31'b0, wdt_rst_o}, 0);
    wr(8'h0C, 32'h8);
    rd(8'h10, d); check("R8 rst event cleared", d, 0);
  endtask

  task automatic t_no_reset_en();
    logic [31:0] d;
    wr(8'h08, 32'h2);
    load(32'd1, 32'd0);
    pulse_tick();
    check("R9 no pulse without enable", {31'b0, wdt_rst_o}, 0);
    rd(8'h10, d); check("R7 event with irq disabled, R9 no rst event", d, 32'h1);
    check("R7 irq disabled by ctrl", {31'b0, irq_o}, 0);
    wr(8'h0C, 32'h9);
  endtask

  initial begin
    total = 0; bad = 0;
    tick = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_busy_and_split();
    t_countdown();
    t_no_reset_en();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule